// File: doc/BRIEF.md
# Float to Signed Fixed-Point Converter

This block turns one IEEE-754 operand into a signed fixed-point integer, truncating toward zero. The operand may be half, single or double precision. The result is 32 or 64 bits wide. The position of the binary point is set per operation by a 6-bit scale code: the number of fraction bits is 64 minus the code. Operations with an illegal encoding are refused, and the refusal shows on a dedicated output.

The converter accepts one operation per clock. Results return two cycles after issue, marked by an output valid. Each result comes with per-operation invalid and inexact flags. The same flags also collect into sticky status bits that only reset clears. No flag ever stops the conversion. A 32-bit result is sign-extended onto the 64-bit result bus.

Top module: `fp_fix_cvt`

## Requirements
- R1: `fmt_i` picks the source format: 2'b00 is single (operand bits [31:0]), 2'b01 is double (bits [63:0]), 2'b11 is half (bits [15:0]), and 2'b10 is illegal and raises `undef_o`.
- R2: Half precision is legal only while the parameter `HALF_EN` is 1. With `HALF_EN` = 0, `fmt_i` = 2'b11 is illegal.
- R3: `size64_i` = 0 selects a 32-bit result, sign-extended to 64 bits on `result_o`. `size64_i` = 1 selects a full 64-bit result.
- R4: The fraction bit count is 64 − `scale_i`, taken as unsigned. With a 32-bit result, a `scale_i` whose bit 5 is 0 is illegal, so the legal range is 1..32. With a 64-bit result the range is 1..64.
- R5: The result is the operand times 2^fraction-bits, truncated toward zero, and this holds for negative operands too.
- R6: Infinity, or a scaled value above 2^(W−1)−1 or below −2^(W−1) for width W, gives the largest or smallest value of W and raises `invalid_o`. Exactly −2^(W−1) is returned with no flag.
- R7: A NaN operand returns zero with `invalid_o` set.
- R8: `inexact_o` is set when truncation drops nonzero bits and the result did not saturate. It is never set together with `invalid_o`.
- R9: Zeros of either sign return 0 with no flag. Subnormal operands are converted at full precision, with no flushing.
- R10: An illegal operation returns `result_o` = 0 and clear flags, and leaves the sticky bits unchanged.
- R11: `sticky_inv_o` and `sticky_inx_o` accumulate the per-operation flags and clear only on reset.
- R12: `valid_o` rises exactly two cycles after `valid_i`, and a new operation may be issued every cycle.
- R13: After reset, `valid_o`, `result_o`, the flags and the sticky bits are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation issue strobe |
| fmt_i | input | 2 | Source format select |
| size64_i | input | 1 | Result width select (0: 32, 1: 64) |
| scale_i | input | 6 | Scale code; fraction bits = 64 − code |
| operand_i | input | 64 | Floating-point operand, right-aligned |
| valid_o | output | 1 | Result valid |
| undef_o | output | 1 | Operation had an illegal encoding |
| result_o | output | 64 | Fixed-point result, sign-extended |
| invalid_o | output | 1 | Invalid-operation flag for this result |
| inexact_o | output | 1 | Inexact flag for this result |
| sticky_inv_o | output | 1 | Accumulated invalid flag |
| sticky_inx_o | output | 1 | Accumulated inexact flag |

## Verification
Some internal faults change only the data. A wrong exponent in the first stage, a wrong shift direction or a bad overflow limit shows up as a wrong `result_o` or a wrong flag on the very next valid result, two cycles after issue. Other faults change the control path. A lost valid or a missed illegal decode shows up as a wrong `valid_o` or `undef_o` in that same cycle. A corrupted sticky bit persists: it stays visible on every later cycle until reset, so the bench compares the sticky bits on every result.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int OUT_W    = 64;
  localparam int NARROW_W = 32;
  localparam int MANT_W   = 53;
  localparam int FRAC_MAX = 64;
  localparam int FB_W     = 7;
  localparam int K_W      = 13;
  localparam int MAG_W    = MANT_W + FRAC_MAX;

  localparam logic [1:0] FMT_SGL = 2'b00;
  localparam logic [1:0] FMT_DBL = 2'b01;
  localparam logic [1:0] FMT_BAD = 2'b10;
  localparam logic [1:0] FMT_HLF = 2'b11;

  // per-format field geometry
  localparam int D_FRAC = 52;
  localparam int D_EXP  = 11;
  localparam int D_BIAS = 1023;
  localparam int S_FRAC = 23;
  localparam int S_EXP  = 8;
  localparam int S_BIAS = 127;
  localparam int H_FRAC = 10;
  localparam int H_EXP  = 5;
  localparam int H_BIAS = 15;

  typedef struct packed {
    logic                     sign;
    logic                     nan;
    logic                     inf;
    logic [MANT_W-1:0]        mant;
    logic signed [K_W-1:0]    expo;
  } unpacked_t;

  typedef struct packed {
    logic                     valid;
    logic                     undef;
    logic                     size64;
    logic                     sign;
    logic                     nan;
    logic                     inf;
    logic [MANT_W-1:0]        mant;
    logic signed [K_W-1:0]    k;
  } stage1_t;
endpackage

// File: rtl/fcvt_decode.sv
module fcvt_decode
  import fcvt_pkg::*;
#(
  parameter bit HALF_EN = 1'b1
) (
  input  logic [1:0]      fmt_i,
  input  logic            size64_i,
  input  logic [5:0]      scale_i,
  output logic            legal_o,
  output logic [FB_W-1:0] fbits_o
);
  logic half_ok;

  generate
    if (HALF_EN) begin : g_half
      assign half_ok = 1'b1;
    end else begin : g_no_half
      assign half_ok = 1'b0;
    end
  endgenerate

  logic fmt_ok;
  always_comb begin
    unique case (fmt_i)
      FMT_SGL, FMT_DBL: fmt_ok = 1'b1;
      FMT_HLF:          fmt_ok = half_ok;
      default:          fmt_ok = 1'b0;
    endcase
  end

  // narrow result needs at most 32 fraction bits
  assign legal_o = fmt_ok && (size64_i || scale_i[5]);
  assign fbits_o = FB_W'(FRAC_MAX) - FB_W'(scale_i);
endmodule

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
  import fcvt_pkg::*;
(
  input  logic [1:0]  fmt_i,
  input  logic [63:0] operand_i,
  output unpacked_t   up_o
);
  logic [D_EXP-1:0]  e_raw;
  logic [D_FRAC-1:0] f_raw;
  logic [D_EXP-1:0]  e_all1;
  logic [K_W-1:0]    bias_adj;
  logic              sgn;

  // normalise all formats onto a 53-bit mantissa with a common exponent
  always_comb begin
    unique case (fmt_i)
      FMT_DBL: begin
        sgn      = operand_i[63];
        e_raw    = operand_i[62:52];
        f_raw    = operand_i[51:0];
        e_all1   = {D_EXP{1'b1}};
        bias_adj = K_W'(D_BIAS + D_FRAC);
      end
      FMT_HLF: begin
        sgn      = operand_i[15];
        e_raw    = D_EXP'(operand_i[14:10]);
        f_raw    = {operand_i[9:0], {(D_FRAC-H_FRAC){1'b0}}};
        e_all1   = D_EXP'({H_EXP{1'b1}});
        bias_adj = K_W'(H_BIAS + D_FRAC);
      end
      default: begin
        sgn      = operand_i[31];
        e_raw    = D_EXP'(operand_i[30:23]);
        f_raw    = {operand_i[22:0], {(D_FRAC-S_FRAC){1'b0}}};
        e_all1   = D_EXP'({S_EXP{1'b1}});
        bias_adj = K_W'(S_BIAS + D_FRAC);
      end
    endcase
  end

  logic          e_zero;
  logic [K_W-1:0] e_eff;

  assign e_zero     = (e_raw == '0);
  assign e_eff      = e_zero ? K_W'(1) : K_W'(e_raw);
  assign up_o.sign  = sgn;
  assign up_o.nan   = (e_raw == e_all1) && (f_raw != '0);
  assign up_o.inf   = (e_raw == e_all1) && (f_raw == '0);
  assign up_o.mant  = {~e_zero, f_raw};
  assign up_o.expo  = $signed(e_eff - bias_adj);
endmodule

// File: rtl/fcvt_scale.sv
module fcvt_scale
  import fcvt_pkg::*;
(
  input  stage1_t          s1_i,
  output logic [OUT_W-1:0] res_o,
  output logic             inv_o,
  output logic             inx_o
);
  localparam logic signed [K_W-1:0] K_HI = K_W'(FRAC_MAX);
  localparam logic signed [K_W-1:0] K_LO = -K_W'(FRAC_MAX);

  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] tmp;
  logic [MAG_W-1:0] lim;
  logic             lost;
  logic             huge;
  logic             ovf;
  logic [6:0]       rsh;
  logic [OUT_W-1:0] signed_v;
  logic [OUT_W-1:0] sat_v;

  assign rsh = 7'(-s1_i.k);

  always_comb begin
    mag  = '0;
    tmp  = '0;
    lost = 1'b0;
    huge = 1'b0;
    if (s1_i.k >= K_HI) begin
      huge = (s1_i.mant != '0);
    end else if (s1_i.k >= 0) begin
      mag = {{FRAC_MAX{1'b0}}, s1_i.mant} << 6'(s1_i.k);
    end else if (s1_i.k >= K_LO) begin
      tmp  = {s1_i.mant, {FRAC_MAX{1'b0}}} >> rsh;
      mag  = MAG_W'(tmp[MAG_W-1:FRAC_MAX]);
      lost = (tmp[FRAC_MAX-1:0] != '0);
    end else begin
      lost = (s1_i.mant != '0);
    end
  end

  // negative side reaches one step further than positive
  assign lim = s1_i.size64 ? (MAG_W'(1) << (OUT_W-1)) : (MAG_W'(1) << (NARROW_W-1));
  assign ovf = huge || (s1_i.sign ? (mag > lim) : (mag >= lim));

  always_comb begin
    if (s1_i.size64)
      sat_v = s1_i.sign ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
    else
      sat_v = s1_i.sign ? {{(OUT_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}}
                        : {{(OUT_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
  end

  logic [OUT_W-1:0] mag_lo;
  assign mag_lo   = mag[OUT_W-1:0];
  assign signed_v = s1_i.sign ? (~mag_lo + OUT_W'(1)) : mag_lo;

  always_comb begin
    res_o = '0;
    inv_o = 1'b0;
    inx_o = 1'b0;
    if (s1_i.nan) begin
      inv_o = 1'b1;
    end else if (s1_i.inf || ovf) begin
      res_o = sat_v;
      inv_o = 1'b1;
    end else begin
      res_o = s1_i.size64 ? signed_v
                          : {{(OUT_W-NARROW_W){signed_v[NARROW_W-1]}}, signed_v[NARROW_W-1:0]};
      inx_o = lost;
    end
  end
endmodule

// File: rtl/fp_fix_cvt.sv
module fp_fix_cvt
  import fcvt_pkg::*;
#(
  parameter bit HALF_EN = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [1:0]  fmt_i,
  input  logic        size64_i,
  input  logic [5:0]  scale_i,
  input  logic [63:0] operand_i,
  output logic        valid_o,
  output logic        undef_o,
  output logic [63:0] result_o,
  output logic        invalid_o,
  output logic        inexact_o,
  output logic        sticky_inv_o,
  output logic        sticky_inx_o
);
  logic            legal;
  logic [FB_W-1:0] fbits;
  unpacked_t       up;
  stage1_t         s1_d, s1_q;

  fcvt_decode #(.HALF_EN(HALF_EN)) u_decode (
    .fmt_i    (fmt_i),
    .size64_i (size64_i),
    .scale_i  (scale_i),
    .legal_o  (legal),
    .fbits_o  (fbits)
  );

  fcvt_unpack u_unpack (
    .fmt_i     (fmt_i),
    .operand_i (operand_i),
    .up_o      (up)
  );

  always_comb begin
    s1_d.valid  = valid_i;
    s1_d.undef  = ~legal;
    s1_d.size64 = size64_i;
    s1_d.sign   = up.sign;
    s1_d.nan    = up.nan;
    s1_d.inf    = up.inf;
    s1_d.mant   = up.mant;
    s1_d.k      = up.expo + $signed(K_W'(fbits));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_q <= '0;
    else         s1_q <= s1_d;
  end

  logic [OUT_W-1:0] res_c;
  logic             inv_c, inx_c;

  fcvt_scale u_scale (
    .s1_i  (s1_q),
    .res_o (res_c),
    .inv_o (inv_c),
    .inx_o (inx_c)
  );

  logic ok_c;
  assign ok_c = s1_q.valid && !s1_q.undef;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      undef_o      <= 1'b0;
      result_o     <= '0;
      invalid_o    <= 1'b0;
      inexact_o    <= 1'b0;
      sticky_inv_o <= 1'b0;
      sticky_inx_o <= 1'b0;
    end else begin
      valid_o      <= s1_q.valid;
      undef_o      <= s1_q.valid && s1_q.undef;
      result_o     <= ok_c ? res_c : '0;
      invalid_o    <= ok_c && inv_c;
      inexact_o    <= ok_c && inx_c;
      sticky_inv_o <= sticky_inv_o | (ok_c && inv_c);
      sticky_inx_o <= sticky_inx_o | (ok_c && inx_c);
    end
  end
endmodule

// File: rtl/fp_fix_cvt_chk.sv
module fp_fix_cvt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [1:0]  fmt_i,
  input logic        size64_i,
  input logic [5:0]  scale_i,
  input logic        valid_o,
  input logic        undef_o,
  input logic [63:0] result_o,
  input logic        invalid_o,
  input logic        inexact_o,
  input logic        sticky_inv_o,
  input logic        sticky_inx_o
);
  p_fmt_illegal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && fmt_i == 2'b10 |-> ##2 (valid_o && undef_o));

  p_scale_narrow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !size64_i && !scale_i[5] |-> ##2 (valid_o && undef_o));

  p_sext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !size64_i |-> ##2 (result_o[63:31] == '0 || result_o[63:31] == '1));

  p_flag_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(invalid_o && inexact_o));

  p_undef_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && undef_o |-> (result_o == '0 && !invalid_o && !inexact_o));

  p_sticky_inv_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_inv_o |=> sticky_inv_o);

  p_sticky_inx_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_inx_o |=> sticky_inx_o);

  p_sticky_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && invalid_o |-> sticky_inv_o) and (valid_o && inexact_o |-> sticky_inx_o));

  p_latency_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);

  p_no_spurious_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);
endmodule

bind fp_fix_cvt fp_fix_cvt_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .fmt_i        (fmt_i),
  .size64_i     (size64_i),
  .scale_i      (scale_i),
  .valid_o      (valid_o),
  .undef_o      (undef_o),
  .result_o     (result_o),
  .invalid_o    (invalid_o),
  .inexact_o    (inexact_o),
  .sticky_inv_o (sticky_inv_o),
  .sticky_inx_o (sticky_inx_o)
);

// File: tb/fp_fix_cvt_bench.sv
`timescale 1ns/1ps
module fp_fix_cvt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  fmt_i = '0;
  logic        size64_i = 1'b0;
  logic [5:0]  scale_i = '0;
  logic [63:0] operand_i = '0;

  logic        valid_o, undef_o, invalid_o, inexact_o, stk_inv, stk_inx;
  logic [63:0] result_o;
  logic        nh_valid, nh_undef, nh_inv, nh_inx, nh_si, nh_sx;
  logic [63:0] nh_result;

  always #2 clk = ~clk;

  fp_fix_cvt u_fp_fix_cvt (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .fmt_i(fmt_i),
    .size64_i(size64_i), .scale_i(scale_i), .operand_i(operand_i),
    .valid_o(valid_o), .undef_o(undef_o), .result_o(result_o),
    .invalid_o(invalid_o), .inexact_o(inexact_o),
    .sticky_inv_o(stk_inv), .sticky_inx_o(stk_inx));

  fp_fix_cvt #(.HALF_EN(1'b0)) u_fp_fix_cvt_nohalf (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .fmt_i(fmt_i),
    .size64_i(size64_i), .scale_i(scale_i), .operand_i(operand_i),
    .valid_o(nh_valid), .undef_o(nh_undef), .result_o(nh_result),
    .invalid_o(nh_inv), .inexact_o(nh_inx),
    .sticky_inv_o(nh_si), .sticky_inx_o(nh_sx));

  typedef struct {
    logic [63:0] res;
    bit          undef;
    bit          inv;
    bit          inx;
  } exp_t;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  localparam int QN = 4096;
  exp_t  q_main [QN];
  exp_t  q_nh   [QN];
  int    q_due  [QN];
  string q_tag  [QN];
  int    wr = 0;
  int    rd = 0;
  bit    m_si = 0;
  bit    m_sx = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [63:0] sat_val(bit sg, int w);
    if (w == 64) return sg ? 64'h8000_0000_0000_0000 : 64'h7fff_ffff_ffff_ffff;
    return sg ? 64'hffff_ffff_8000_0000 : 64'h0000_0000_7fff_ffff;
  endfunction

  function automatic exp_t model(bit [1:0] fmt, bit sz, bit [5:0] scale, bit [63:0] op, bit hen);
    exp_t e;
    int fw, ew, bias, ebits, fb, w;
    longint unsigned frac;
    longint mag;
    bit sg;
    real val, v, m, lim;
    e.res = '0; e.undef = 0; e.inv = 0; e.inx = 0;
    if (fmt == 2'b10 || (fmt == 2'b11 && !hen) || (!sz && !scale[5])) begin
      e.undef = 1;
      return e;
    end
    case (fmt)
      2'b00:   begin fw = 23; ew = 8;  end
      2'b01:   begin fw = 52; ew = 11; end
      default: begin fw = 10; ew = 5;  end
    endcase
    bias  = (1 << (ew - 1)) - 1;
    frac  = op & ((64'd1 << fw) - 1);
    ebits = int'((op >> fw) & ((64'd1 << ew) - 1));
    sg    = op[fw + ew];
    fb    = 64 - int'(scale);
    w     = sz ? 64 : 32;
    if (ebits == (1 << ew) - 1) begin
      e.inv = 1;
      if (frac == 0) e.res = sat_val(sg, w);
      return e;
    end
    if (ebits == 0) val = real'(frac) * 2.0 ** (1 - bias - fw);
    else            val = (real'(frac) + 2.0 ** fw) * 2.0 ** (ebits - bias - fw);
    v   = val * 2.0 ** fb;
    m   = $floor(v);
    lim = 2.0 ** (w - 1);
    if ((!sg && m >= lim) || (sg && m > lim)) begin
      e.res = sat_val(sg, w);
      e.inv = 1;
      return e;
    end
    e.inx = (v != m);
    if (m == 2.0 ** 63) e.res = 64'h8000_0000_0000_0000;
    else begin
      mag   = longint'(m);
      e.res = sg ? -mag : mag;
    end
    return e;
  endfunction

  // called at a falling edge; sampled at the next rising edge
  task automatic issue(bit [1:0] fmt, bit sz, bit [5:0] scale, bit [63:0] op, string tag);
    valid_i   = 1'b1;
    fmt_i     = fmt;
    size64_i  = sz;
    scale_i   = scale;
    operand_i = op;
    q_main[wr % QN] = model(fmt, sz, scale, op, 1'b1);
    q_nh[wr % QN]   = model(fmt, sz, scale, op, 1'b0);
    q_due[wr % QN]  = cyc + 2;
    q_tag[wr % QN]  = tag;
    wr++;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit   want;
      exp_t e, en;
      want = (rd < wr) && (q_due[rd % QN] == cyc);
      check(valid_o === want, "R12", "valid_o", 64'(valid_o), 64'(want));
      if (want && valid_o === 1'b1) begin
        e  = q_main[rd % QN];
        en = q_nh[rd % QN];
        check(result_o === e.res, q_tag[rd % QN], "result", result_o, e.res);
        check(undef_o === e.undef && invalid_o === e.inv && inexact_o === e.inx,
              q_tag[rd % QN], "flags{undef,inv,inx}",
              64'({undef_o, invalid_o, inexact_o}), 64'({e.undef, e.inv, e.inx}));
        m_si = m_si | e.inv;
        m_sx = m_sx | e.inx;
        check(stk_inv === m_si && stk_inx === m_sx, "R11", "sticky",
              64'({stk_inv, stk_inx}), 64'({m_si, m_sx}));
        check(nh_undef === en.undef && nh_result === en.res, "R2", "no-half result",
              nh_result, en.res);
        rd++;
      end
    end
  end

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    fork
      begin
        #(4ns * 190000);
        if (!done) begin
          done = 1;
          bad++;
          total++;
          $display("FAIL watchdog: actual=timeout expected=finish");
          $display("  test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none

    void'($urandom(32'd4242));
    idle(3);
    // R13 reset state
    check(valid_o === 0 && result_o === '0 && invalid_o === 0 && inexact_o === 0,
          "R13", "reset outputs", result_o, 64'd0);
    check(stk_inv === 0 && stk_inx === 0 && undef_o === 0, "R13", "reset sticky",
          64'({stk_inv, stk_inx}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R10 illegal first: sticky must stay clear
    issue(2'b10, 1, 6'd10, $realtobits(-1.0e30), "R1");
    issue(2'b01, 0, 6'd31, $realtobits(1.0e30), "R4");
    issue(2'b01, 0, 6'd5, 64'h7ff8_0000_0000_0000, "R10");
    idle(3);
    // R1 format decode
    issue(2'b00, 1, 6'd62, 64'hdead_beef_3fc0_0000, "R1");
    issue(2'b01, 1, 6'd62, $realtobits(1.5), "R1");
    // R2 half
    issue(2'b11, 0, 6'd60, 64'h0000_0000_0000_3c00, "R2");
    issue(2'b11, 1, 6'd62, 64'h0000_0000_0000_c100, "R2");
    // R4 scale limits
    issue(2'b01, 0, 6'd32, $realtobits(0.25), "R4");
    issue(2'b01, 1, 6'd0, $realtobits(0.25), "R4");
    issue(2'b01, 0, 6'd63, $realtobits(3.0), "R4");
    // R5 truncation toward zero
    issue(2'b01, 0, 6'd63, $realtobits(-2.75), "R5");
    issue(2'b01, 0, 6'd63, $realtobits(2.75), "R5");
    issue(2'b01, 1, 6'd63, $realtobits(-0.75), "R5");
    // R3 width and sign extension
    issue(2'b01, 0, 6'd60, $realtobits(-3.0), "R3");
    issue(2'b01, 1, 6'd32, $realtobits(-3.0), "R3");
    // R6 saturation and extremes
    issue(2'b01, 0, 6'd63, $realtobits(1073741823.5), "R6");
    issue(2'b01, 0, 6'd63, $realtobits(1073741824.0), "R6");
    issue(2'b01, 0, 6'd63, $realtobits(-1073741824.0), "R6");
    issue(2'b01, 0, 6'd63, $realtobits(-1073741824.5), "R6");
    issue(2'b01, 1, 6'd63, $realtobits(4611686018427387904.0), "R6");
    issue(2'b01, 1, 6'd63, $realtobits(-4611686018427387904.0), "R6");
    issue(2'b01, 1, 6'd40, 64'h7ff0_0000_0000_0000, "R6");
    issue(2'b00, 0, 6'd40, 64'h0000_0000_ff80_0000, "R6");
    issue(2'b01, 1, 6'd1, $realtobits(1.0), "R6");
    // R7 NaN
    issue(2'b01, 1, 6'd50, 64'hfff8_0000_0000_0001, "R7");
    issue(2'b11, 0, 6'd50, 64'h0000_0000_0000_7e00, "R7");
    // R8 exact vs inexact
    issue(2'b01, 1, 6'd63, $realtobits(1.0), "R8");
    issue(2'b00, 1, 6'd63, 64'h0000_0000_3eaa_aaab, "R8");
    // R9 zero and subnormal
    issue(2'b01, 1, 6'd0, 64'h0000_0000_0000_0001, "R9");
    issue(2'b11, 0, 6'd34, 64'h0000_0000_0000_0001, "R9");
    issue(2'b00, 1, 6'd0, 64'h0000_0000_0000_0001, "R9");
    issue(2'b01, 0, 6'd33, 64'h8000_0000_0000_0000, "R9");
    issue(2'b11, 1, 6'd0, 64'h0000_0000_0000_8000, "R9");
    // R10 illegal after flags set
    issue(2'b10, 1, 6'd3, 64'h7ff0_0000_0000_0000, "R10");
    idle(4);

    // R5 random, back to back
    for (int i = 0; i < 1500; i++) begin
      bit [1:0] f;
      bit sz, sg;
      bit [5:0] sc;
      int fw, ew, bias, fb, w, ue, be, maxe;
      logic [63:0] op, fr;
      case ($urandom % 3)
        0:       begin f = 2'b00; fw = 23; ew = 8;  end
        1:       begin f = 2'b01; fw = 52; ew = 11; end
        default: begin f = 2'b11; fw = 10; ew = 5;  end
      endcase
      sz   = $urandom % 2;
      sc   = sz ? 6'($urandom % 64) : 6'(32 + $urandom % 32);
      if ($urandom % 50 == 0) sc = 6'($urandom % 64);
      fb   = 64 - int'(sc);
      w    = sz ? 64 : 32;
      bias = (1 << (ew - 1)) - 1;
      maxe = (1 << ew) - 1;
      ue   = int'($urandom % (w + 10)) - fb - 5;
      be   = ue + bias;
      if (be < 0) be = 0;
      if (be >= maxe) be = maxe - 1;
      sg   = $urandom % 2;
      fr   = rnd64() & ((64'd1 << fw) - 1);
      op   = rnd64() & ~((64'd1 << (fw + ew + 1)) - 1);
      op   = op | (64'(sg) << (fw + ew)) | (64'(be) << fw) | fr;
      valid_i   = 1'b1;
      fmt_i     = f;
      size64_i  = sz;
      scale_i   = sc;
      operand_i = op;
      q_main[wr % QN] = model(f, sz, sc, op, 1'b1);
      q_nh[wr % QN]   = model(f, sz, sc, op, 1'b0);
      q_due[wr % QN]  = cyc + 2;
      q_tag[wr % QN]  = "R5";
      wr++;
      @(negedge clk);
    end
    valid_i = 1'b0;
    idle(5);

    done = 1;
    check(rd == wr, "R12", "results drained", 64'(rd), 64'(wr));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule